// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address and Control Front-End

This block models a synchronous burst static RAM together with the address and control logic in front of it. Every input is sampled on the rising clock edge. Two active-low address strobes can start an access. One belongs to a processor and always begins a read. The other belongs to a memory controller and begins a read or a write, as the byte write enables select. Three chip enables qualify each strobe. Each strobe follows its own rule when the primary enable is inactive.

After a start, an active-low advance input steps a 2-bit beat counter through a four-beat burst. The mode input picks the beat order: linear when low, interleaved when high. Data is held in byte lanes, and each lane carries a parity bit that is stored and returned exactly as written. Read data leaves through a registered output stage that has an explicit output-enable. While the device is deselected, that stage is switched off.

Top module: `sbs_sram`

## Requirements
- R1: Processor strobe low, primary enable low, ce2 high and ce2_n low on an edge: the address is registered as beat 0 of a new read burst, and any burst in progress is abandoned.
- R2: A cycle started by the processor strobe is a read, even when write enables are low and the controller strobe is also low; no byte is written on that edge.
- R3: While the primary enable is high, the processor strobe has no effect; if the controller strobe is high, the burst state continues as if no strobe were present, so the advance input still steps it.
- R4: Processor strobe accepted with ce2 low or ce2_n high: the device becomes deselected.
- R5: Controller strobe low, with the processor strobe not accepted and all three enables active: the address is registered; the burst is a write when any wen_n bit is low, otherwise a read.
- R6: Controller strobe low with the primary enable high, or with ce2 low or ce2_n high: the device becomes deselected.
- R7: mode_il low: beat k of a burst uses low address bits (start + k) mod 4; the upper bits stay those of the start address.
- R8: mode_il high: beat k uses low address bits start XOR k.
- R9: With no strobe and adv_n low in an active burst, the beat advances by one and wraps from 3 back to 0, keeping the burst type. With adv_n high the beat holds and nothing is written.
- R10: Data read at the address held after edge k appears on dq/dqp with dq_oe high after edge k+1. When not reading, dq_oe is low and dq/dqp are zero.
- R11: A write beat (start or advance) updates only the lanes whose wen_n bit is low (bit i is lane i, dq bits 8i+7..8i, parity bit i). Parity is returned unchanged.
- R12: While reset is held, dq_oe is low, dq/dqp are zero, and the device is deselected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strb_proc_n | input | 1 | Processor address strobe, active low |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| ce_n | input | 1 | Primary chip enable, active low |
| ce2 | input | 1 | Secondary chip enable, active high |
| ce2_n | input | 1 | Secondary chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| wen_n | input | LANES | Per-lane write enables, active low |
| mode_il | input | 1 | Burst order: 0 linear, 1 interleaved; static while active |
| addr | input | AW | Word address |
| wdata | input | 8*LANES | Write data, lane i in bits 8i+7..8i |
| wpar | input | LANES | Write parity, bit i for lane i |
| dq | output | 8*LANES | Registered read data |
| dqp | output | LANES | Registered read parity |
| dq_oe | output | 1 | Output drive enable |

## Verification
First, every word of the array is filled through controller write bursts in linear order. This shows whether the beat counter walks all four offsets of each aligned group. Reads from mid-group start offsets, run in both orders, separate the modulo-add sequence from the XOR sequence, and the reads run past the fourth beat to expose the wrap. Strobe collisions are also tried: the processor strobe with write enables low and the controller strobe low, the processor strobe with the primary enable high in the middle of a burst, and each enable inactive in turn. These show which strobe wins and whether a stray write or restart slips through. Lane-masked writes with distinct parity values, followed by hold cycles, show which bytes are touched and confirm that a stalled write burst stores nothing.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned LANE_W = BYTE_W + 1;

  // low-address offset of a beat: modulo-4 add or XOR
  function automatic logic [1:0] beat_ofs(input logic [1:0] start,
                                          input logic [1:0] beat,
                                          input logic       il);
    return il ? (start ^ beat) : (start + beat);
  endfunction
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strb_proc_n,
  input  logic             strb_ctl_n,
  input  logic             ce_n,
  input  logic             ce2,
  input  logic             ce2_n,
  input  logic             adv_n,
  input  logic [LANES-1:0] wen_n,
  input  logic             mode_il,
  input  logic [AW-1:0]    addr,
  output logic [AW-1:0]    rd_addr,
  output logic             rd_act,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [LANES-1:0] wr_mask
);
  import sbs_pkg::*;

  logic          act_q, act_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] base_q, base_d;
  logic [1:0]    beat_q, beat_d;
  logic          move;

  logic proc_acc, sec_ok;
  assign proc_acc = !strb_proc_n && !ce_n;
  assign sec_ok   = ce2 && !ce2_n;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    base_d = base_q;
    beat_d = beat_q;
    move   = 1'b0;
    if (proc_acc) begin
      act_d  = sec_ok;
      wr_d   = 1'b0;
      base_d = addr;
      beat_d = 2'd0;
    end else if (!strb_ctl_n) begin
      act_d  = !ce_n && sec_ok;
      wr_d   = (wen_n != {LANES{1'b1}});
      base_d = addr;
      beat_d = 2'd0;
      move   = 1'b1;
    end else if (act_q && !adv_n) begin
      beat_d = beat_q + 2'd1;
      move   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      base_q <= base_d;
      beat_q <= beat_d;
    end
  end

  assign rd_addr = {base_q[AW-1:2], beat_ofs(base_q[1:0], beat_q, mode_il)};
  assign rd_act  = act_q && !wr_q;
  assign wr_addr = {base_d[AW-1:2], beat_ofs(base_d[1:0], beat_d, mode_il)};
  assign wr_en   = act_d && wr_d && move;
  assign wr_mask = ~wen_n;
endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [LANES-1:0]                mask,
  input  logic [AW-1:0]                   waddr,
  input  logic [LANES*sbs_pkg::LANE_W-1:0] wword,
  input  logic [AW-1:0]                   raddr,
  output logic [LANES*sbs_pkg::LANE_W-1:0] rword
);
  import sbs_pkg::*;
  localparam int unsigned DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && mask[g]) mem[waddr] <= wword[g*LANE_W +: LANE_W];
    end
    assign rword[g*LANE_W +: LANE_W] = mem[raddr];
  end
endmodule

// File: rtl/sbs_outreg.sv
module sbs_outreg #(
  parameter int unsigned LANES = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             rd_act,
  input  logic [LANES*sbs_pkg::LANE_W-1:0] rword,
  output logic [LANES*sbs_pkg::BYTE_W-1:0] dq,
  output logic [LANES-1:0]                 dqp,
  output logic                             dq_oe
);
  import sbs_pkg::*;

  logic [LANES*BYTE_W-1:0] dq_d;
  logic [LANES-1:0]        dqp_d;

  always_comb begin
    dq_d  = '0;
    dqp_d = '0;
    for (int i = 0; i < LANES; i++) begin
      if (rd_act) begin
        dq_d[i*BYTE_W +: BYTE_W] = rword[i*LANE_W +: BYTE_W];
        dqp_d[i]                 = rword[i*LANE_W + BYTE_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dq    <= '0;
      dqp   <= '0;
      dq_oe <= 1'b0;
    end else begin
      dq    <= dq_d;
      dqp   <= dqp_d;
      dq_oe <= rd_act;
    end
  end
endmodule

// File: rtl/sbs_sram.sv
module sbs_sram #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  strb_proc_n,
  input  logic                  strb_ctl_n,
  input  logic                  ce_n,
  input  logic                  ce2,
  input  logic                  ce2_n,
  input  logic                  adv_n,
  input  logic [LANES-1:0]      wen_n,
  input  logic                  mode_il,
  input  logic [AW-1:0]         addr,
  input  logic [LANES*8-1:0]    wdata,
  input  logic [LANES-1:0]      wpar,
  output logic [LANES*8-1:0]    dq,
  output logic [LANES-1:0]      dqp,
  output logic                  dq_oe
);
  import sbs_pkg::*;
  localparam int unsigned WW = LANES * LANE_W;

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic [AW-1:0]    rd_addr, wr_addr;
  logic             rd_act, wr_en;
  logic [LANES-1:0] wr_mask;
  logic [WW-1:0]    wword, rword;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign wword[g*LANE_W +: LANE_W] = {wpar[g], wdata[g*BYTE_W +: BYTE_W]};
  end

  sbs_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .adv_n(adv_n),
    .wen_n(wen_n), .mode_il(mode_il), .addr(addr),
    .rd_addr(rd_addr), .rd_act(rd_act),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_mask(wr_mask)
  );

  sbs_array #(.AW(AW), .LANES(LANES)) u_array (
    .clk(clk), .we(wr_en), .mask(wr_mask), .waddr(wr_addr),
    .wword(wword), .raddr(rd_addr), .rword(rword)
  );

  sbs_outreg #(.LANES(LANES)) u_out (
    .clk(clk), .rst_n(rst_sync_n), .rd_act(rd_act), .rword(rword),
    .dq(dq), .dqp(dqp), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/sbs_sram_chk.sv
module sbs_sram_chk #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               strb_proc_n,
  input logic               strb_ctl_n,
  input logic               ce_n,
  input logic               ce2,
  input logic               ce2_n,
  input logic [LANES-1:0]   wen_n,
  input logic [AW-1:0]      addr,
  input logic [LANES*8-1:0] dq,
  input logic [LANES-1:0]   dqp,
  input logic               dq_oe
);
  // R1: an accepted processor start drives data two edges later
  p_proc_read_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !ce_n && ce2 && !ce2_n) |=> ##1 dq_oe);

  // R3: processor strobe with primary enable high changes nothing
  p_proc_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ce_n && !strb_proc_n && strb_ctl_n) |=> ##1 (dq_oe == $past(dq_oe)));

  // R4: processor strobe with a secondary enable off deselects
  p_proc_secoff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_proc_n && !ce_n && !(ce2 && !ce2_n)) |=> ##1 !dq_oe);

  // R5: controller start with any write enable low is a write burst
  p_ctl_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (strb_proc_n && !strb_ctl_n && !ce_n && ce2 && !ce2_n &&
     (wen_n != {LANES{1'b1}})) |=> ##1 !dq_oe);

  // R6: controller strobe with primary enable high deselects
  p_ctl_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strb_ctl_n && ce_n) |=> ##1 !dq_oe);

  // R10: undriven outputs read as zero
  p_quiet_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq == '0 && dqp == '0));

  logic unused_ok;
  assign unused_ok = ^addr;
endmodule

bind sbs_sram sbs_sram_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .strb_proc_n(strb_proc_n), .strb_ctl_n(strb_ctl_n),
  .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .wen_n(wen_n), .addr(addr),
  .dq(dq), .dqp(dqp), .dq_oe(dq_oe)
);

// File: tb/sbs_sram_test.sv
`timescale 1ns/1ps
module sbs_sram_test;
  localparam int AW = 6;
  localparam int LN = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, sp_n, sc_n, ce_n, ce2, ce2_n, adv_n, mode_il;
  logic [LN-1:0]   wen_n, wpar, dqp;
  logic [AW-1:0]   addr;
  logic [LN*8-1:0] wdata, dq;
  logic            dq_oe;

  sbs_sram #(.AW(AW), .LANES(LN)) uut (
    .clk(clk), .rst_n(rst_n), .strb_proc_n(sp_n), .strb_ctl_n(sc_n),
    .ce_n(ce_n), .ce2(ce2), .ce2_n(ce2_n), .adv_n(adv_n), .wen_n(wen_n),
    .mode_il(mode_il), .addr(addr), .wdata(wdata), .wpar(wpar),
    .dq(dq), .dqp(dqp), .dq_oe(dq_oe)
  );

  int total = 0, bad = 0;
  string tag = "R12";
  bit done = 0;

  // behavioural reference
  int m_mem [64][LN];
  bit m_act, m_wr;
  int m_base, m_beat;
  bit e_oe;
  logic [LN*8-1:0] e_dq;
  logic [LN-1:0]   e_par;

  function automatic int beat_addr(int base, int beat, bit il);
    int lo;
    lo = il ? ((base & 3) ^ beat) : (((base & 3) + beat) % 4);
    return (base & ~3) | lo;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_wr = 0; m_base = 0; m_beat = 0;
      e_oe = 0; e_dq = '0; e_par = '0;
    end else begin
      bit moved;
      int a;
      moved = 0;
      if (m_act && !m_wr) begin
        a = beat_addr(m_base, m_beat, mode_il);
        e_oe = 1;
        for (int i = 0; i < LN; i++) begin
          e_dq[i*8 +: 8] = m_mem[a][i][7:0];
          e_par[i]       = m_mem[a][i][8];
        end
      end else begin
        e_oe = 0; e_dq = '0; e_par = '0;
      end
      if (!sp_n && !ce_n) begin
        m_act = ce2 && !ce2_n; m_wr = 0; m_base = addr; m_beat = 0;
      end else if (!sc_n) begin
        m_act = !ce_n && ce2 && !ce2_n; m_wr = (wen_n != '1);
        m_base = addr; m_beat = 0; moved = 1;
      end else if (m_act && !adv_n) begin
        m_beat = (m_beat + 1) % 4; moved = 1;
      end
      if (m_act && m_wr && moved) begin
        a = beat_addr(m_base, m_beat, mode_il);
        for (int i = 0; i < LN; i++)
          if (!wen_n[i]) m_mem[a][i] = {23'd0, wpar[i], wdata[i*8 +: 8]};
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      total++;
      if (dq_oe !== e_oe || dq !== e_dq || dqp !== e_par) begin
        bad++;
        $display("FAIL %s: oe=%b dq=%h dqp=%b expected oe=%b dq=%h dqp=%b",
                 tag, dq_oe, dq, dqp, e_oe, e_dq, e_par);
      end
    end
  end

  task automatic cyc(input bit sp, input bit sc, input bit cn, input bit c2,
                     input bit c2n, input bit av, input logic [LN-1:0] we,
                     input int a, input logic [15:0] d, input logic [1:0] p);
    sp_n = sp; sc_n = sc; ce_n = cn; ce2 = c2; ce2_n = c2n; adv_n = av;
    wen_n = we; addr = a[AW-1:0]; wdata = d; wpar = p;
    @(posedge clk); #1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 1, 0, 1, '1, 0, 0, 0);
  endtask

  task automatic adv(input int n);
    for (int i = 0; i < n; i++) cyc(1, 1, 0, 1, 0, 0, '1, 0, 16'hFFFF, 0);
  endtask

  function automatic logic [15:0] pat(int a);
    return 16'((a * 16'h0925) ^ 16'h5A3C);
  endfunction

  initial begin
    rst_n = 0; mode_il = 0;
    sp_n = 1; sc_n = 1; ce_n = 0; ce2 = 1; ce2_n = 0; adv_n = 1;
    wen_n = '1; addr = '0; wdata = '0; wpar = '0;
    repeat (4) @(posedge clk);
    #1;
    tag = "R12"; idle(1);
    rst_n = 1;
    idle(3);
    // R5 / R9: fill by controller write bursts, linear order
    tag = "R5";
    for (int b = 0; b < 16; b++) begin
      cyc(1, 0, 0, 1, 0, 1, 2'b00, b*4, pat(b*4), 2'(b*4));
      for (int k = 1; k < 4; k++)
        cyc(1, 1, 0, 1, 0, 0, 2'b00, 0, pat(b*4+k), 2'(b*4+k));
    end
    tag = "R6"; cyc(1, 0, 1, 1, 0, 1, '1, 0, 0, 0); idle(2);
    // R7 linear, mid-group start, hold and wrap
    tag = "R7"; cyc(0, 1, 0, 1, 0, 1, '1, 14, 0, 0);
    adv(2); tag = "R9"; idle(2); adv(4);
    tag = "R10"; cyc(1, 0, 1, 1, 0, 1, '1, 0, 0, 0); idle(2);
    // R8 interleaved
    mode_il = 1; idle(1);
    tag = "R8"; cyc(0, 1, 0, 1, 0, 1, '1, 13, 0, 0); adv(5);
    cyc(0, 1, 0, 1, 0, 0, '1, 46, 0, 0); adv(4);
    // R3 processor strobe ignored with primary enable high
    tag = "R3"; cyc(0, 1, 0, 1, 0, 1, '1, 20, 0, 0); adv(1);
    cyc(0, 1, 1, 1, 0, 0, '1, 40, 0, 0); adv(2);
    cyc(0, 1, 1, 1, 0, 1, 2'b00, 9, 16'h1111, 2'b11); adv(1);
    // R4 secondary enables
    tag = "R4"; cyc(0, 1, 0, 0, 0, 1, '1, 5, 0, 0); idle(2);
    cyc(0, 1, 0, 1, 0, 1, '1, 5, 0, 0); adv(1);
    cyc(0, 1, 0, 1, 1, 1, '1, 5, 0, 0); idle(2);
    // R1 restart mid burst
    tag = "R1"; cyc(0, 1, 0, 1, 0, 1, '1, 25, 0, 0); adv(1);
    cyc(0, 1, 0, 1, 0, 0, '1, 50, 0, 0); adv(3);
    // R2 processor strobe beats write enables and controller strobe
    tag = "R2"; cyc(0, 0, 0, 1, 0, 0, 2'b00, 8, 16'hDEAD, 2'b01);
    cyc(1, 1, 0, 1, 0, 0, 2'b00, 0, 16'hBEEF, 2'b10); adv(3);
    cyc(0, 1, 0, 1, 0, 1, '1, 8, 0, 0); adv(4);
    // R11 lane-masked writes, stalled write burst
    mode_il = 0;
    tag = "R11"; cyc(1, 0, 0, 1, 0, 1, 2'b10, 32, 16'hABCD, 2'b11);
    cyc(1, 1, 0, 1, 0, 0, 2'b01, 0, 16'h1234, 2'b10);
    tag = "R9"; cyc(1, 1, 0, 1, 0, 1, 2'b00, 0, 16'h7777, 2'b11);
    tag = "R11"; cyc(1, 1, 0, 1, 0, 0, 2'b11, 0, 16'h9999, 2'b11);
    cyc(1, 1, 0, 1, 0, 0, 2'b00, 0, 16'h0F0F, 2'b01);
    cyc(0, 1, 0, 1, 0, 1, '1, 32, 0, 0); adv(5);
    // R5 controller read, R6 secondary off
    tag = "R5"; cyc(1, 0, 0, 1, 0, 1, 2'b11, 34, 0, 0); adv(3);
    tag = "R6"; cyc(1, 0, 0, 0, 0, 1, '1, 34, 0, 0); idle(2);
    cyc(0, 1, 0, 1, 0, 1, '1, 3, 0, 0); adv(1);
    cyc(1, 0, 1, 1, 0, 0, '1, 3, 0, 0); idle(2);
    tag = "R10"; idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule